// File: doc/BRIEF.md
# Sub-word Register Access Adapter

This block lets a host port that issues 1-, 2- or 4-byte accesses talk to register targets that only accept aligned 32-bit words. The host presents a byte offset inside a 128-byte little-endian window, a size, a direction and write data in its low-order bytes, then holds the request until the adapter answers with a one-cycle `host_ready` pulse.

The window holds three decode regions of different sizes: sixteen protocol-core words, eight DMA words and a single bus-control word at offset 0x70. A full aligned write goes straight to the target. A narrower or unaligned write becomes a read-modify-write: the adapter fetches the current word, replaces only the addressed byte lanes and writes the merged word back. A read fetches the word and returns it shifted down to the addressed lane and masked to the requested size. Unmapped offsets read as zero and ignore writes. An access whose bytes would run past a word boundary, or whose size is not 1, 2 or 4, is ignored.

The register targets sit outside the block. They see a read strobe, a write strobe, a region code, a word index and the write word, and return read data on one input per region in the same cycle.

Top module: `swa_adapter`

## Requirements
- R1: After reset `host_ready`, `tgt_rd` and `tgt_wr` are 0 and `host_rdata` is zero.
- R2: The word address `host_addr[6:2]` selects the region driven on `tgt_region`: code 1 (core, index = word) for offsets 0x00-0x3F, code 2 (DMA, index = word - 16) for 0x40-0x5F, code 3 (control, index 0) for 0x70-0x73, code 0 elsewhere; no strobe ever reaches a word other than the addressed one.
- R3: A write of size 4 with `host_addr[1:0]` = 0 to a mapped word issues exactly one `tgt_wr` carrying `host_wdata` unchanged and no `tgt_rd`; `host_ready` rises two cycles after the request is taken, and `host_rdata` reads zero.
- R4: Any other legal write to a mapped word issues one `tgt_rd` with `tgt_rmw` = 1, then in the next cycle one `tgt_wr` whose lanes `host_addr[1:0]` up to `host_addr[1:0]+size-1` hold the low bytes of `host_wdata` in order and whose other lanes equal the fetched word; `host_ready` follows the write by one cycle, three cycles after the request.
- R5: A legal read of a mapped word issues one `tgt_rd` with `tgt_rmw` = 0 and returns the fetched word shifted right by 8 x `host_addr[1:0]` and masked to 8 x size bits; `host_ready` rises two cycles after the request.
- R6: A read of an unmapped word returns zero and a write to one is dropped; neither raises a strobe and `host_ready` rises one cycle after the request.
- R7: An access with size (`host_size`, in bytes) not 1, 2 or 4, or with `host_addr[1:0]` + size greater than 4, raises no strobe, returns zero and is acknowledged one cycle after the request.
- R8: `host_ready` is high for exactly one cycle per access, and `tgt_rd` and `tgt_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | 7 | Byte offset in the window |
| host_size | input | 3 | Access size in bytes (1, 2 or 4) |
| host_wdata | input | 32 | Write bytes, right-aligned |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Right-aligned read result, valid with `host_ready` |
| tgt_rd | output | 1 | Word fetch strobe to the targets |
| tgt_wr | output | 1 | Word write strobe to the targets |
| tgt_rmw | output | 1 | Marks a fetch made for a read-modify-write |
| tgt_region | output | 2 | Region code (0 none, 1 core, 2 DMA, 3 control) |
| tgt_idx | output | 4 | Word index inside the region |
| tgt_wdata | output | 32 | Word written to the target |
| core_rdata | input | 32 | Core region word at `tgt_idx` |
| dma_rdata | input | 32 | DMA region word at `tgt_idx` |
| ctrl_rdata | input | 32 | Control word |

## Verification
On every cycle the assertions hold the strobe ordering of the read-modify-write, the untouched lanes of each merged word against the word fetched the cycle before, the absence of a fetch ahead of a full aligned write, the single-cycle acknowledge and the silent handling of dropped accesses. Only the bench's scenarios show that the right lane data lands in the right target word, that read results are extracted correctly at each offset and size, that each path has its stated latency, and that no other target word changed; a closing sweep compares every target word with an independent byte-level model of the window.

// File: rtl/swa_pkg.sv
package swa_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CORE = 2'd1,
    RGN_DMA  = 2'd2,
    RGN_CTRL = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2,
    ST_ACK   = 2'd3
  } state_e;

  // Size must be 1, 2 or 4 and the bytes must stay inside one word.
  function automatic logic access_legal(input logic [1:0] off, input logic [2:0] size);
    logic size_ok;
    size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    return size_ok && ((int'(off) + int'(size)) <= WORD_BYTES);
  endfunction

  // One bit per byte lane touched by the access.
  function automatic logic [WORD_BYTES-1:0] lane_mask(input logic [1:0] off, input logic [2:0] size);
    logic [WORD_BYTES-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_BYTES; i++) begin
      if ((i >= int'(off)) && (i < int'(off) + int'(size))) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Expand a lane mask to a bit mask.
  function automatic logic [WORD_BITS-1:0] bit_mask(input logic [WORD_BYTES-1:0] lanes);
    logic [WORD_BITS-1:0] b;
    for (int i = 0; i < WORD_BYTES; i++) b[8*i +: 8] = {8{lanes[i]}};
    return b;
  endfunction

  // Right-align the addressed lanes of a word and clear the rest.
  function automatic logic [WORD_BITS-1:0] extract_lanes(input logic [WORD_BITS-1:0] w,
                                                         input logic [1:0] off,
                                                         input logic [2:0] size);
    logic [WORD_BITS-1:0] s;
    s = w >> {off, 3'b000};
    case (size)
      3'd1:    return {24'h0, s[7:0]};
      3'd2:    return {16'h0, s[15:0]};
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/swa_region_dec.sv
module swa_region_dec
  import swa_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int IDX_W       = 4,
  parameter int CORE_WORDS  = 16,
  parameter int DMA_WORDS   = 8,
  parameter int CTRL_OFFSET = 'h70
) (
  input  logic [ADDR_W-1:2] word_addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] DMA_LO  = WORD_W'(CORE_WORDS);
  localparam logic [WORD_W-1:0] DMA_HI  = WORD_W'(CORE_WORDS + DMA_WORDS);
  localparam logic [WORD_W-1:0] CTRL_WD = WORD_W'(CTRL_OFFSET / 4);

  logic [WORD_W-1:0] word;
  assign word = word_addr;

  always_comb begin
    region = RGN_NONE;
    idx    = '0;
    if (word < DMA_LO) begin
      region = RGN_CORE;
      idx    = IDX_W'(word);
    end else if (word < DMA_HI) begin
      region = RGN_DMA;
      idx    = IDX_W'(word - DMA_LO);
    end else if (word == CTRL_WD) begin
      region = RGN_CTRL;
    end
  end

endmodule

// File: rtl/swa_lane_unit.sv
module swa_lane_unit
  import swa_pkg::*;
(
  input  logic [WORD_BITS-1:0] cur_word,
  input  logic [WORD_BITS-1:0] fetch_word,
  input  logic [WORD_BITS-1:0] new_bytes,
  input  logic [1:0]           off,
  input  logic [2:0]           size,
  output logic [WORD_BITS-1:0] merged,
  output logic [WORD_BITS-1:0] extracted
);

  logic [WORD_BYTES-1:0] lanes;
  logic [WORD_BITS-1:0]  shifted;

  assign lanes     = lane_mask(off, size);
  assign shifted   = new_bytes << {off, 3'b000};
  assign extracted = extract_lanes(fetch_word, off, size);

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign merged[8*g +: 8] = lanes[g] ? shifted[8*g +: 8] : cur_word[8*g +: 8];
  end

endmodule

// File: rtl/swa_seq.sv
module swa_seq
  import swa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 we,
  input  logic                 full,
  input  logic                 legal,
  input  logic                 hit,
  input  logic [WORD_BITS-1:0] fetch_word,
  input  logic [WORD_BITS-1:0] fetch_lanes,
  output logic                 rd_stb,
  output logic                 wr_stb,
  output logic                 rmw_stb,
  output logic                 ready,
  output logic                 drop,
  output logic [WORD_BITS-1:0] word_q,
  output logic [WORD_BITS-1:0] rdata_q
);

  state_e st, nx;

  always_comb begin
    nx   = st;
    drop = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req) begin
          if (!legal || !hit) begin
            drop = 1'b1;
            nx   = ST_ACK;
          end else if (we && full) begin
            nx = ST_WRITE;
          end else begin
            nx = ST_FETCH;
          end
        end
      end
      ST_FETCH: nx = we ? ST_WRITE : ST_ACK;
      ST_WRITE: nx = ST_ACK;
      default:  nx = ST_IDLE;
    endcase
  end

  assign rd_stb  = (st == ST_FETCH);
  assign wr_stb  = (st == ST_WRITE);
  assign rmw_stb = (st == ST_FETCH) && we;
  assign ready   = (st == ST_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      word_q  <= '0;
      rdata_q <= '0;
    end else begin
      st <= nx;
      if (st == ST_IDLE && req) rdata_q <= '0;
      if (st == ST_FETCH) begin
        word_q <= fetch_word;
        if (!we) rdata_q <= fetch_lanes;
      end
    end
  end

endmodule

// File: rtl/swa_adapter.sv
module swa_adapter
  import swa_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int IDX_W       = 4,
  parameter int CORE_WORDS  = 16,
  parameter int DMA_WORDS   = 8,
  parameter int CTRL_OFFSET = 'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [2:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic              host_ready,
  output logic [31:0]       host_rdata,
  output logic              tgt_rd,
  output logic              tgt_wr,
  output logic              tgt_rmw,
  output logic [1:0]        tgt_region,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic [31:0]       tgt_wdata,
  input  logic [31:0]       core_rdata,
  input  logic [31:0]       dma_rdata,
  input  logic [31:0]       ctrl_rdata
);

  logic [1:0]     off;
  logic           legal, full, hit;
  region_e        region;
  logic [31:0]    sel_rdata, word_q, merged, extracted;

  // Named internal events for the checker.
  logic ev_fetch, ev_commit, ev_drop;

  assign off   = host_addr[1:0];
  assign legal = access_legal(off, host_size);
  assign full  = (host_size == 3'd4) && (off == 2'd0);
  assign hit   = (region != RGN_NONE);

  swa_region_dec #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CORE_WORDS(CORE_WORDS),
    .DMA_WORDS(DMA_WORDS), .CTRL_OFFSET(CTRL_OFFSET)
  ) u_dec (
    .word_addr(host_addr[ADDR_W-1:2]),
    .region   (region),
    .idx      (tgt_idx)
  );

  always_comb begin
    case (region)
      RGN_CORE: sel_rdata = core_rdata;
      RGN_DMA:  sel_rdata = dma_rdata;
      RGN_CTRL: sel_rdata = ctrl_rdata;
      default:  sel_rdata = '0;
    endcase
  end

  swa_lane_unit u_lane (
    .cur_word  (word_q),
    .fetch_word(sel_rdata),
    .new_bytes (host_wdata),
    .off       (off),
    .size      (host_size),
    .merged    (merged),
    .extracted (extracted)
  );

  swa_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (host_req),
    .we         (host_we),
    .full       (full),
    .legal      (legal),
    .hit        (hit),
    .fetch_word (sel_rdata),
    .fetch_lanes(extracted),
    .rd_stb     (ev_fetch),
    .wr_stb     (ev_commit),
    .rmw_stb    (tgt_rmw),
    .ready      (host_ready),
    .drop       (ev_drop),
    .word_q     (word_q),
    .rdata_q    (host_rdata)
  );

  assign tgt_rd     = ev_fetch;
  assign tgt_wr     = ev_commit;
  assign tgt_region = region;
  assign tgt_wdata  = full ? host_wdata : merged;

endmodule

// File: rtl/swa_adapter_chk.sv
module swa_adapter_chk
  import swa_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [1:0]  off,
  input logic [2:0]  host_size,
  input logic        host_ready,
  input logic [31:0] host_rdata,
  input logic        tgt_rd,
  input logic        tgt_wr,
  input logic        tgt_rmw,
  input logic [1:0]  tgt_region,
  input logic [31:0] tgt_wdata,
  input logic [31:0] core_rdata,
  input logic [31:0] dma_rdata,
  input logic [31:0] ctrl_rdata,
  input logic        ev_drop
);

  logic        whole;
  logic [31:0] keep_bits, fetched;

  assign whole     = (host_size == 3'd4) && (off == 2'd0);
  assign keep_bits = ~bit_mask(lane_mask(off, host_size));

  always_comb begin
    case (tgt_region)
      2'd1:    fetched = core_rdata;
      2'd2:    fetched = dma_rdata;
      2'd3:    fetched = ctrl_rdata;
      default: fetched = '0;
    endcase
  end

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tgt_rd && tgt_wr));

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  p_write_mapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr |-> (tgt_region != 2'd0));

  p_fetch_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && !whole) |-> ($past(tgt_rd) && $past(tgt_rmw)));

  p_keep_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && !whole) |-> (((tgt_wdata ^ $past(fetched)) & keep_bits) == 32'h0));

  p_commit_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr |=> host_ready);

  p_no_fetch_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && whole) |-> !$past(tgt_rd));

  p_read_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_rd && !host_we) |-> !tgt_rmw);

  p_drop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (host_ready && (host_rdata == 32'h0) && !tgt_rd && !tgt_wr));

endmodule

bind swa_adapter swa_adapter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_we   (host_we),
  .off       (host_addr[1:0]),
  .host_size (host_size),
  .host_ready(host_ready),
  .host_rdata(host_rdata),
  .tgt_rd    (tgt_rd),
  .tgt_wr    (tgt_wr),
  .tgt_rmw   (tgt_rmw),
  .tgt_region(tgt_region),
  .tgt_wdata (tgt_wdata),
  .core_rdata(core_rdata),
  .dma_rdata (dma_rdata),
  .ctrl_rdata(ctrl_rdata),
  .ev_drop   (ev_drop)
);

// File: tb/swa_adapter_tb.sv
`timescale 1ns/1ps
module swa_adapter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [2:0]  host_size = 3'd4;
  logic [31:0] host_wdata = '0;
  logic        host_ready, tgt_rd, tgt_wr, tgt_rmw;
  logic [31:0] host_rdata, tgt_wdata;
  logic [1:0]  tgt_region;
  logic [3:0]  tgt_idx;
  logic [31:0] core_rdata, dma_rdata, ctrl_rdata;

  always #2.5 clk = ~clk;

  swa_adapter u_dut (.*);

  int checks = 0, failures = 0;

  // Target stubs
  logic [31:0] core_mem [16];
  logic [31:0] dma_mem  [8];
  logic [31:0] ctrl_reg;
  assign core_rdata = core_mem[tgt_idx];
  assign dma_rdata  = dma_mem[tgt_idx[2:0]];
  assign ctrl_rdata = ctrl_reg;

  int n_rd = 0, n_wr = 0;
  logic [1:0] s_region;
  logic [3:0] s_idx;
  logic       s_rmw;

  always @(posedge clk) begin
    if (tgt_rd) begin
      n_rd++; s_region = tgt_region; s_idx = tgt_idx; s_rmw = tgt_rmw;
    end
    if (tgt_wr) begin
      n_wr++; s_region = tgt_region; s_idx = tgt_idx;
      case (tgt_region)
        2'd1: core_mem[tgt_idx] <= tgt_wdata;
        2'd2: dma_mem[tgt_idx[2:0]] <= tgt_wdata;
        2'd3: ctrl_reg <= tgt_wdata;
        default: ;
      endcase
    end
  end

  // Independent byte-level model of the window.
  logic [7:0] mdl [128];

  function automatic bit mapped(input int a);
    int w = a / 4;
    return (w < 24) || (w == 28);
  endfunction

  function automatic bit legal(input int a, input int sz);
    return (sz == 1 || sz == 2 || sz == 4) && ((a % 4) + sz <= 4);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // {we, addr, size, wdata, latency, reads, writes}
  localparam int NV = 21;
  localparam logic [49:0] TBL [NV] = '{
    {1'b0, 7'h04, 3'd4, 32'h0,        3'd2, 2'd1, 2'd0},
    {1'b0, 7'h05, 3'd1, 32'h0,        3'd2, 2'd1, 2'd0},
    {1'b0, 7'h06, 3'd2, 32'h0,        3'd2, 2'd1, 2'd0},
    {1'b1, 7'h08, 3'd4, 32'h11223344, 3'd2, 2'd0, 2'd1},
    {1'b1, 7'h09, 3'd1, 32'hFFFFFFAB, 3'd3, 2'd1, 2'd1},
    {1'b1, 7'h0A, 3'd2, 32'h0000BEEF, 3'd3, 2'd1, 2'd1},
    {1'b0, 7'h08, 3'd4, 32'h0,        3'd2, 2'd1, 2'd0},
    {1'b1, 7'h5E, 3'd2, 32'h99991234, 3'd3, 2'd1, 2'd1},
    {1'b0, 7'h5C, 3'd4, 32'h0,        3'd2, 2'd1, 2'd0},
    {1'b1, 7'h73, 3'd1, 32'h0000005A, 3'd3, 2'd1, 2'd1},
    {1'b0, 7'h70, 3'd4, 32'h0,        3'd2, 2'd1, 2'd0},
    {1'b0, 7'h72, 3'd2, 32'h0,        3'd2, 2'd1, 2'd0},
    {1'b0, 7'h64, 3'd4, 32'h0,        3'd1, 2'd0, 2'd0},
    {1'b1, 7'h78, 3'd4, 32'hDEADBEEF, 3'd1, 2'd0, 2'd0},
    {1'b1, 7'h61, 3'd1, 32'h000000EE, 3'd1, 2'd0, 2'd0},
    {1'b0, 7'h03, 3'd2, 32'h0,        3'd1, 2'd0, 2'd0},
    {1'b1, 7'h42, 3'd4, 32'hCAFEF00D, 3'd1, 2'd0, 2'd0},
    {1'b0, 7'h00, 3'd3, 32'h0,        3'd1, 2'd0, 2'd0},
    {1'b0, 7'h3F, 3'd1, 32'h0,        3'd2, 2'd1, 2'd0},
    {1'b1, 7'h40, 3'd1, 32'h00000077, 3'd3, 2'd1, 2'd1},
    {1'b0, 7'h40, 3'd4, 32'h0,        3'd2, 2'd1, 2'd0}
  };

  task automatic access(input bit we, input int a, input int sz, input logic [31:0] wd,
                        input int exp_lat, input int exp_rd, input int exp_wr);
    int rd0 = n_rd, wr0 = n_wr, lat = 0;
    bit ok_path = legal(a, sz) && mapped(a);
    logic [31:0] exp_data = '0;
    string tag;
    if (!ok_path)           tag = legal(a, sz) ? "R6" : "R7";
    else if (!we)           tag = "R5";
    else if (sz == 4 && a % 4 == 0) tag = "R3";
    else                    tag = "R4";
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = 7'(a); host_size = 3'(sz); host_wdata = wd;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!host_ready && lat < 20);
    if (ok_path && !we)
      for (int k = 0; k < sz; k++) exp_data[8*k +: 8] = mdl[a + k];
    if (ok_path && we)
      for (int k = 0; k < sz; k++) mdl[a + k] = wd[8*k +: 8];
    check(lat == exp_lat, tag, "latency", lat, exp_lat);
    check(host_rdata == exp_data, tag, "rdata", host_rdata, exp_data);
    check(n_rd - rd0 == exp_rd, tag, "fetch count", n_rd - rd0, exp_rd);
    check(n_wr - wr0 == exp_wr, tag, "write count", n_wr - wr0, exp_wr);
    if (exp_rd != 0)
      check(s_rmw == we, tag, "rmw flag", s_rmw, we);
    if (exp_rd + exp_wr != 0) begin
      int er = (a < 'h40) ? 1 : (a < 'h60) ? 2 : 3;
      int ei = (a < 'h40) ? a / 4 : (a < 'h60) ? (a - 'h40) / 4 : 0;
      check(s_region == 2'(er), "R2", "region", s_region, er);
      check(s_idx == 4'(ei), "R2", "index", s_idx, ei);
    end
    host_req = 1'b0;
    @(negedge clk);
    check(host_ready == 1'b0, "R8", "ready pulse width", host_ready, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) core_mem[i] = 32'hC0000000 + i * 32'h01020304;
    for (int i = 0; i < 8; i++)  dma_mem[i]  = 32'hD0000000 + i * 32'h00050709;
    ctrl_reg = 32'h1357A5C3;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 4; k++) mdl[4*i + k] = core_mem[i][8*k +: 8];
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 4; k++) mdl['h40 + 4*i + k] = dma_mem[i][8*k +: 8];
    for (int k = 0; k < 4; k++) mdl['h70 + k] = ctrl_reg[8*k +: 8];

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(host_ready == 1'b0, "R1", "ready in reset", host_ready, 0);
    check(!tgt_rd && !tgt_wr, "R1", "strobes in reset", {tgt_rd, tgt_wr}, 0);
    check(host_rdata == 32'h0, "R1", "rdata in reset", host_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_ready == 1'b0 && !tgt_rd && !tgt_wr, "R1", "idle after reset",
          {host_ready, tgt_rd, tgt_wr}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [49:0] e = TBL[v];
      access(e[49], int'(e[48:42]), int'(e[41:39]), e[38:7],
             int'(e[6:4]), int'(e[3:2]), int'(e[1:0]));
    end

    // Corner cases: every lane of a DMA word, crossing writes at each offset.
    for (int o = 0; o < 4; o++) access(1'b1, 'h48 + o, 1, 32'(8'h10 + o), 3, 1, 1);
    access(1'b0, 'h48, 4, 32'h0, 2, 1, 0);
    for (int o = 1; o < 4; o++) access(1'b1, 'h14 + o, 4, 32'h55555555, 1, 0, 0);
    access(1'b1, 'h1D, 2, 32'h0000A1B2, 3, 1, 1);
    access(1'b0, 'h1D, 2, 32'h0, 2, 1, 0);

    // R2/R6: no stray writes anywhere in the window.
    for (int i = 0; i < 16; i++)
      check(core_mem[i] == {mdl[4*i+3], mdl[4*i+2], mdl[4*i+1], mdl[4*i]},
            "R2", "core word", core_mem[i], {mdl[4*i+3], mdl[4*i+2], mdl[4*i+1], mdl[4*i]});
    for (int i = 0; i < 8; i++)
      check(dma_mem[i] == {mdl['h43+4*i], mdl['h42+4*i], mdl['h41+4*i], mdl['h40+4*i]},
            "R6", "dma word", dma_mem[i],
            {mdl['h43+4*i], mdl['h42+4*i], mdl['h41+4*i], mdl['h40+4*i]});
    check(ctrl_reg == {mdl['h73], mdl['h72], mdl['h71], mdl['h70]}, "R6", "ctrl word",
          ctrl_reg, {mdl['h73], mdl['h72], mdl['h71], mdl['h70]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule